// File: doc/BRIEF.md
# Serial SAR Converter Frame and Power Controller

This block is the digital side of a successive-approximation converter that is driven entirely by an external host. The host frames each conversion with an active-low select and supplies a serial clock. Both inputs are asynchronous to the block. They are synchronised into a faster system clock, and their edges are detected in that domain. On the select falling edge, the block latches a parallel result word and puts the sample-and-hold into hold. It then shifts a fixed 16-bit frame onto a data line with a separate output enable. The frame starts with four zero bits, then the result MSB first, then zero padding. With a 12-bit result there is no padding; with a 10-bit result there are two trailing zeros.

The host sets the power state purely by where in the frame it releases the select line. The block counts serial clock falling edges since the select fell. Releasing early in the frame, but not too early, powers the block down. A later dummy frame that runs long enough wakes it up again. The windows reject short glitches in both directions. A wake-up takes a fixed number of system clocks. The frame that performs the wake-up is marked as not carrying a valid result. Straight binary coding passes through unchanged.

Top module: `sar_serial_if`

## Requirements
- R1: After reset the data enable is 0, the hold flag is 0, the powered flag is 1 and the frame-valid pulse is 0.
- R2: When the select falls, the result input is captured, the hold flag goes to 1, the data enable goes to 1 and the data line carries 0.
- R3: After the k-th serial clock fall, for k from 1 to 15, the data line carries bit 15-k of the frame word. The frame word is four zeros above the result. In 10-bit mode it is also followed by two zeros, so the result occupies bits 11:2. The data line does not change on serial clock rises.
- R4: On the 16th serial clock fall the data enable drops to 0. It stays 0 while the select remains low.
- R5: A select rise before the 16th fall aborts the frame: the data enable and the hold flag return to 0.
- R6: The hold flag stays 1 through the 13th serial clock fall. It drops to 0 on the first serial clock rise after that fall.
- R7: While powered, releasing the select after 2 to 9 falls clears the powered flag. Releasing it after fewer than 2 falls, or after 10 or more, leaves the flag set.
- R8: While powered down, a frame released before its 10th fall keeps the block powered down. A frame that reaches its 10th fall sets the powered flag once PWRUP_CYCLES system clocks have passed since that frame's select fall.
- R9: The frame-valid output pulses for exactly one cycle on the 16th fall of a frame that began while powered. It does not pulse for a wake-up frame or an aborted frame.
- R10: Changes of the result input after the capture do not alter the shifted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Asynchronous active-low frame select |
| sclk | input | 1 | Asynchronous serial clock, idles high |
| sample | input | RES_BITS | Parallel conversion result, straight binary |
| sdo | output | 1 | Serial data bit, 0 when not enabled |
| sdo_en | output | 1 | Output enable of the data line (0 = high impedance) |
| hold | output | 1 | 1 = sample-and-hold in hold, 0 = track |
| power_good | output | 1 | 1 = fully powered |
| frame_valid | output | 1 | One-cycle pulse at the end of a valid complete frame |

## Verification
Two instances, one 12-bit and one 10-bit, run from the same select and serial clock. This shows that the padding variant changes only the bit positions, never the timing. Full frames use alternating, all-ones and all-zero results, which expose bit-order and padding faults. The result input is changed mid-frame to separate a captured word from a live one. Aborted frames are released after 1, 4, 5, 9, 10 and 12 falls, plus full frames with and without power. These land on each side of the power-down and wake-up window boundaries.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;
  localparam int FRAME_LEN         = 16;
  localparam int LEAD_ZEROS        = 4;
  localparam int DOWN_FROM_FALLS   = 2;
  localparam int KEEP_UP_FALLS     = 10;
  localparam int TRACK_AFTER_FALLS = 13;
  localparam int CNT_W             = $clog2(FRAME_LEN + 1);

  typedef enum logic [1:0] {
    PW_ON   = 2'd0,
    PW_OFF  = 2'd1,
    PW_RAMP = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  localparam int W = STAGES + 1;

  logic [W-1:0] pipe_q;
  logic [W-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[W-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {W{RESET_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[W-2] & ~pipe_q[W-1];
  assign fall = ~pipe_q[W-2] & pipe_q[W-1];
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import sar_if_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_fall,
  input  logic                cs_rise,
  input  logic                sclk_fall,
  input  logic                sclk_rise,
  input  logic                pwr_on,
  input  logic [RES_BITS-1:0] sample,
  output logic                sdo,
  output logic                sdo_en,
  output logic                hold,
  output logic                frame_valid,
  output logic [CNT_W-1:0]    fall_cnt
);
  localparam int TRAIL_ZEROS = FRAME_LEN - LEAD_ZEROS - RES_BITS;

  logic [FRAME_LEN-1:0] word;

  generate
    if (TRAIL_ZEROS == 0) begin : g_no_trail
      assign word = {{LEAD_ZEROS{1'b0}}, sample};
    end else begin : g_trail
      assign word = {{LEAD_ZEROS{1'b0}}, sample, {TRAIL_ZEROS{1'b0}}};
    end
  endgenerate

  logic                 active_q, active_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic                 en_q, en_d;
  logic                 hold_q, hold_d;
  logic                 ok_q, ok_d;
  logic                 valid_q, valid_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    en_d     = en_q;
    hold_d   = hold_q;
    ok_d     = ok_q;
    valid_d  = 1'b0;
    if (cs_fall) begin
      active_d = 1'b1;
      cnt_d    = '0;
      sh_d     = word;
      en_d     = 1'b1;
      hold_d   = 1'b1;
      ok_d     = pwr_on;
    end else if (cs_rise) begin
      active_d = 1'b0;
      en_d     = 1'b0;
      hold_d   = 1'b0;
    end else if (active_q) begin
      if (sclk_fall) begin
        cnt_d = cnt_q + 1'b1;
        sh_d  = {sh_q[FRAME_LEN-2:0], 1'b0};
        if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
          active_d = 1'b0;
          en_d     = 1'b0;
          valid_d  = ok_q;
        end
      end else if (sclk_rise && cnt_q >= CNT_W'(TRACK_AFTER_FALLS)) begin
        hold_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      en_q     <= 1'b0;
      hold_q   <= 1'b0;
      ok_q     <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      en_q     <= en_d;
      hold_q   <= hold_d;
      ok_q     <= ok_d;
      valid_q  <= valid_d;
    end
  end

  assign sdo         = en_q & sh_q[FRAME_LEN-1];
  assign sdo_en      = en_q;
  assign hold        = hold_q;
  assign frame_valid = valid_q;
  assign fall_cnt    = cnt_q;
endmodule

// File: rtl/power_ctl.sv
module power_ctl
  import sar_if_pkg::*;
#(
  parameter int PWRUP_CYCLES = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic [CNT_W-1:0] fall_cnt,
  output logic             power_good
);
  localparam int TMR_W = $clog2(PWRUP_CYCLES + 1);

  pwr_state_e       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             armed_q, armed_d;
  logic             tmr_en, reached_keep, in_down_win, tmr_done;

  assign reached_keep = fall_cnt >= CNT_W'(KEEP_UP_FALLS);
  assign in_down_win  = (fall_cnt >= CNT_W'(DOWN_FROM_FALLS)) && !reached_keep;
  assign tmr_done     = tmr_q == TMR_W'(PWRUP_CYCLES);
  assign tmr_en       = (st_q == PW_RAMP) && !tmr_done;

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    armed_d = armed_q;
    if (tmr_en) tmr_d = tmr_q + 1'b1;
    case (st_q)
      PW_ON: begin
        if (cs_rise && in_down_win) st_d = PW_OFF;
      end
      PW_OFF: begin
        if (cs_fall) begin
          st_d    = PW_RAMP;
          tmr_d   = '0;
          armed_d = 1'b0;
        end
      end
      PW_RAMP: begin
        if (reached_keep) armed_d = 1'b1;
        if (cs_rise && !armed_q && !reached_keep) st_d = PW_OFF;
        else if ((armed_q || reached_keep) && tmr_done) st_d = PW_ON;
      end
      default: st_d = PW_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PW_ON;
      tmr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      armed_q <= armed_d;
    end
  end

  assign power_good = st_q == PW_ON;
endmodule

// File: rtl/sar_serial_if.sv
module sar_serial_if
  import sar_if_pkg::*;
#(
  parameter int RES_BITS     = 12,
  parameter int SYNC_STAGES  = 2,
  parameter int PWRUP_CYCLES = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic [RES_BITS-1:0] sample,
  output logic                sdo,
  output logic                sdo_en,
  output logic                hold,
  output logic                power_good,
  output logic                frame_valid
);
  logic             cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic [CNT_W-1:0] fall_cnt;

  edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cs_n), .rise(cs_rise), .fall(cs_fall)
  );

  edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk), .rise(sclk_rise), .fall(sclk_fall)
  );

  frame_seq #(.RES_BITS(RES_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
    .pwr_on(power_good), .sample(sample),
    .sdo(sdo), .sdo_en(sdo_en), .hold(hold),
    .frame_valid(frame_valid), .fall_cnt(fall_cnt)
  );

  power_ctl #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_power (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .fall_cnt(fall_cnt), .power_good(power_good)
  );
endmodule

// File: rtl/sar_serial_if_chk.sv
module sar_serial_if_chk (
  input logic clk,
  input logic rst_n,
  input logic sdo_en,
  input logic hold,
  input logic power_good,
  input logic frame_valid
);
  // R9
  fv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R9
  fv_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> power_good);

  // R2
  drive_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> hold);

  // R7
  down_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(power_good) |-> !sdo_en);
endmodule

bind sar_serial_if sar_serial_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdo_en(sdo_en), .hold(hold),
  .power_good(power_good), .frame_valid(frame_valid)
);

// File: tb/sar_serial_if_bench.sv
module sar_serial_if_bench;
  typedef struct {
    bit    en;
    bit    b12;
    bit    b10;
    bit    hd;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] smp = '0;
  logic sdo12, en12, hold12, pg12, fv12;
  logic sdo10, en10, hold10, pg10, fv10;
  int   vectors = 0;
  int   fails = 0;
  int   fv12_n = 0;
  int   fv10_n = 0;
  exp_t exp_q[$];
  event smp_ev;

  always #5 clk = ~clk;

  sar_serial_if u_sar_serial_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(smp),
    .sdo(sdo12), .sdo_en(en12), .hold(hold12), .power_good(pg12), .frame_valid(fv12)
  );

  sar_serial_if #(.RES_BITS(10)) u_sar_serial_if_10 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(smp[11:2]),
    .sdo(sdo10), .sdo_en(en10), .hold(hold10), .power_good(pg10), .frame_valid(fv10)
  );

  always @(posedge clk) begin
    if (fv12) fv12_n <= fv12_n + 1;
    if (fv10) fv10_n <= fv10_n + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops the expected item and compares both instances
  initial begin
    forever begin
      exp_t it;
      @(smp_ev);
      it = exp_q.pop_front();
      check({it.tag, " en12"}, 32'(en12), 32'(it.en));
      check({it.tag, " en10"}, 32'(en10), 32'(it.en));
      check({it.tag, " hold12"}, 32'(hold12), 32'(it.hd));
      check({it.tag, " hold10"}, 32'(hold10), 32'(it.hd));
      if (it.en) begin
        check({it.tag, " sdo12"}, 32'(sdo12), 32'(it.b12));
        check({it.tag, " sdo10"}, 32'(sdo10), 32'(it.b10));
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(bit en, bit b12, bit b10, bit hd, string tag);
    exp_t it;
    it.en = en; it.b12 = b12; it.b10 = b10; it.hd = hd; it.tag = tag;
    exp_q.push_back(it);
    -> smp_ev;
    #1;
  endtask

  // driver: one frame released after nf serial clock falls
  task automatic run_frame(logic [11:0] s, int nf);
    logic [15:0] w12, w10;
    w12 = {4'b0000, s};
    w10 = {4'b0000, s[11:2], 2'b00};
    smp = s;
    tick(1);
    cs_n = 1'b0;
    tick(8);
    push(1'b1, 1'b0, 1'b0, 1'b1, "R2");
    smp = ~s; // R10: the captured word must be shifted, not the live input
    tick(2);
    for (int k = 1; k <= nf; k++) begin
      int idx;
      idx = (k < 16) ? 15 - k : 0;
      sclk = 1'b0;
      tick(8);
      push(k < 16, (k < 16) ? w12[idx] : 1'b0, (k < 16) ? w10[idx] : 1'b0,
           k <= 13, (k >= 16) ? "R4" : "R3");
      tick(2);
      sclk = 1'b1;
      tick(8);
      push(k < 16, (k < 16) ? w12[idx] : 1'b0, (k < 16) ? w10[idx] : 1'b0,
           k < 13, "R6");
      tick(2);
    end
    cs_n = 1'b1;
    tick(8);
    push(1'b0, 1'b0, 1'b0, 1'b0, (nf >= 16) ? "R4" : "R5");
    tick(12);
  endtask

  task automatic check_pg(string req, bit exp);
    check({req, " pg12"}, 32'(pg12), 32'(exp));
    check({req, " pg10"}, 32'(pg10), 32'(exp));
  endtask

  task automatic check_fv(string req, int exp);
    check({req, " fv12"}, 32'(fv12_n), 32'(exp));
    check({req, " fv10"}, 32'(fv10_n), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    check("R1 en", 32'({en12, en10}), 32'h0);
    check("R1 hold", 32'({hold12, hold10}), 32'h0);
    check("R1 pg", 32'({pg12, pg10}), 32'h3);
    check("R1 fv", 32'({fv12, fv10}), 32'h0);

    run_frame(12'hA5C, 16);
    check_pg("R7 full frame", 1'b1);
    check_fv("R9 valid frame", 1);

    run_frame(12'h123, 1);
    check_pg("R7 one fall", 1'b1);
    check_fv("R9 aborted", 1);

    run_frame(12'h456, 5);
    check_pg("R7 five falls", 1'b0);
    check_fv("R9 aborted down", 1);

    run_frame(12'h789, 4);
    tick(150);
    check_pg("R8 short wake", 1'b0);

    run_frame(12'hC3A, 16);
    check_pg("R8 dummy frame", 1'b1);
    check_fv("R9 wake frame", 1);

    run_frame(12'hFFF, 16);
    check_fv("R9 valid all ones", 2);
    run_frame(12'h000, 16);
    check_fv("R9 valid zeros", 3);
    run_frame(12'h5A3, 16);
    check_fv("R10 valid", 4);

    run_frame(12'h6B7, 12);
    check_pg("R7 twelve falls", 1'b1);

    run_frame(12'h0F0, 10);
    check_pg("R7 ten falls", 1'b1);

    run_frame(12'h9E1, 9);
    check_pg("R7 nine falls", 1'b0);

    run_frame(12'h3C5, 10);
    check_pg("R8 ten fall wake", 1'b1);
    check_fv("R9 final", 4);

    tick(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule